// File: doc/BRIEF.md
# Dual-Identity I2C Register Target

This block is the target side of a two-wire serial bus. It answers two 7-bit device identifiers, and each identifier opens its own register space: a clock-register bank and a user memory bank. The open-drain bus is seen as two input levels and one drive-low enable for the data line. Both lines pass through two-flop synchronisers. START and STOP conditions are recovered from the synchronised levels, and the block then walks the transfer one bit at a time on the system clock.

A transfer begins with a slave byte, which holds the identifier and a direction bit. In a write, a one-byte word address follows and loads a single address counter, which both banks share. Data bytes come after it. A read that starts right after a STOP uses the counter as it stands. A random read sets the counter with a write-direction slave byte and a word address, then sends a repeated START and a read-direction slave byte. Each bank is reached through a plain synchronous port: the shared address, the write data, one write strobe per bank and one read-data input per bank.

Top module: `dual_id_i2c_target`

## Requirements
- R1: Only identifier 7'b1101111 (clock bank) or 7'b1010111 (memory bank) in bits 7..1 of the slave byte is acknowledged. Any other identifier gets no acknowledge, and the target stays silent until the next START or STOP.
- R2: Bit 0 of the slave byte selects the direction: 1 is a read from the selected bank, 0 is a write.
- R3: To acknowledge, the target drives SDA low for the whole ninth clock. It does this after a matching slave byte, after the word address byte and after each write data byte. It releases SDA when that clock falls, unless read data follows.
- R4: The word address byte loads the shared address counter. Reset clears the counter to 00h, so a read issued right after reset returns location 00h.
- R5: The counter advances by one after each data byte, whether read or written, and wraps from FFh to 00h. It keeps its value across STOP and across a change of bank.
- R6: A write data byte is committed at the end of its acknowledge clock. The commit is a single-cycle strobe to the selected bank only, carrying the current counter value and the received byte.
- R7: In a random read, a read-direction slave byte after the dummy write must carry the same identifier as the dummy write. If it does not, the target gives no acknowledge.
- R8: Read data goes out MSB first, and each bit changes only while SCL is low. When the controller acknowledges, the next location follows. When the controller does not acknowledge, the target releases SDA and waits for STOP or START.
- R9: A STOP in the middle of a byte aborts that byte. Nothing is written, and the counter keeps its value.
- R10: The target never changes its SDA drive while SCL is high, and its drive level is stable for the whole high phase of every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaDrvLow | output | 1 | Pull the data line low when 1 |
| regAddr | output | ADDR_W | Shared word address counter, used by both banks |
| wrData | output | 8 | Byte to be written |
| clkWe | output | 1 | Write strobe for the clock-register bank |
| memWe | output | 1 | Write strobe for the user memory bank |
| clkRdData | input | 8 | Clock-bank contents at regAddr |
| memRdData | input | 8 | Memory-bank contents at regAddr |

## Verification
The assertions assume that every SCL high and low phase lasts longer than the synchroniser and event latency, which is three system clocks. They also assume that the controller changes SDA only while SCL is low, except when it makes a START or a STOP, and that it never makes a START or a STOP while the target is driving SDA. The stimulus keeps to these rules. Each SCL quarter period lasts five system clocks. Data is placed one quarter after SCL falls. Conditions are issued only after the target has released the line, and the bench samples the line inside the high phase.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    stIdle, stDev, stDevAck, stWaddr, stWaddrAck,
    stWdata, stWdataAck, stRdata, stRack, stWait
  } ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadTx;
    logic shiftOut;
    logic setAddr;
    logic incAddr;
    logic commit;
    logic drvAck;
    logic drvRel;
    logic selMem;
  } dpCmd_t;

  // bus events from datapath to control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startEv;
    logic stopEv;
    logic sdaBit;
  } busEv_t;
endpackage

// File: rtl/i2ct_dp.sv
module i2ct_dp
  import i2ct_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCmd_t            cmd,
  output busEv_t            ev,
  output logic [BYTE_W-1:0] rxByte,
  output logic              sdaDrvLow,
  output logic [ADDR_W-1:0] regAddr,
  output logic [BYTE_W-1:0] wrData,
  output logic              clkWe,
  output logic              memWe,
  input  logic [BYTE_W-1:0] clkRdData,
  input  logic [BYTE_W-1:0] memRdData
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic                   sclP, sdaP;
  logic [BYTE_W-1:0]      shReg;
  logic [ADDR_W-1:0]      addrCnt;
  logic                   drv;
  logic [BYTE_W-1:0]      rdSel;
  logic                   sclS, sdaS;

  assign sclS  = sclSh[LAST];
  assign sdaS  = sdaSh[LAST];
  assign rdSel = cmd.selMem ? memRdData : clkRdData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSh <= '1;
      sdaSh <= '1;
      sclP  <= 1'b1;
      sdaP  <= 1'b1;
    end else begin
      sclSh <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclP  <= sclS;
      sdaP  <= sdaS;
    end
  end

  assign ev.sclRise = sclS & ~sclP;
  assign ev.sclFall = ~sclS & sclP;
  assign ev.startEv = sclS & sclP & sdaP & ~sdaS;
  assign ev.stopEv  = sclS & sclP & ~sdaP & sdaS;
  assign ev.sdaBit  = sdaS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg   <= '0;
      drv     <= 1'b0;
      addrCnt <= '0;
    end else begin
      if (cmd.shiftIn)       shReg <= {shReg[BYTE_W-2:0], sdaS};
      else if (cmd.loadTx)   shReg <= rdSel;
      else if (cmd.shiftOut) shReg <= {shReg[BYTE_W-2:0], 1'b0};

      if (cmd.loadTx)        drv <= ~rdSel[BYTE_W-1];
      else if (cmd.shiftOut) drv <= ~shReg[BYTE_W-2];
      else if (cmd.drvAck)   drv <= 1'b1;
      else if (cmd.drvRel)   drv <= 1'b0;

      if (cmd.setAddr)       addrCnt <= shReg[ADDR_W-1:0];
      else if (cmd.incAddr)  addrCnt <= addrCnt + 1'b1;
    end
  end

  assign rxByte    = shReg;
  assign wrData    = shReg;
  assign regAddr   = addrCnt;
  assign sdaDrvLow = drv;
  assign clkWe     = cmd.commit & ~cmd.selMem;
  assign memWe     = cmd.commit & cmd.selMem;
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
#(
  parameter logic [6:0] CLK_ID = 7'b1101111,
  parameter logic [6:0] MEM_ID = 7'b1010111
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEv_t            ev,
  input  logic [BYTE_W-1:0] rxByte,
  output dpCmd_t            cmd
);
  localparam logic [3:0] FULL = 4'(BYTE_W);

  ctlState_t state, stateN;
  logic [3:0] cnt, cntN;
  logic selMem, selMemN, rdMode, rdModeN;
  logic dummyPend, dummyPendN, dummyMem, dummyMemN;
  logic ackSeen, ackSeenN;
  logic hitClk, hitMem, rdReq, idOk;

  assign hitClk = rxByte[7:1] == CLK_ID;
  assign hitMem = rxByte[7:1] == MEM_ID;
  assign rdReq  = rxByte[0];
  assign idOk   = (hitClk | hitMem) &&
                  !(rdReq && dummyPend && (hitMem != dummyMem));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= stIdle;
      cnt       <= '0;
      selMem    <= 1'b0;
      rdMode    <= 1'b0;
      dummyPend <= 1'b0;
      dummyMem  <= 1'b0;
      ackSeen   <= 1'b0;
    end else begin
      state     <= stateN;
      cnt       <= cntN;
      selMem    <= selMemN;
      rdMode    <= rdModeN;
      dummyPend <= dummyPendN;
      dummyMem  <= dummyMemN;
      ackSeen   <= ackSeenN;
    end
  end

  always_comb begin
    stateN = state; cntN = cnt; selMemN = selMem; rdModeN = rdMode;
    dummyPendN = dummyPend; dummyMemN = dummyMem; ackSeenN = ackSeen;
    cmd = '0;
    cmd.selMem = selMem;
    if (ev.startEv) begin
      stateN = stDev; cntN = '0; cmd.drvRel = 1'b1;
    end else if (ev.stopEv) begin
      stateN = stIdle; cmd.drvRel = 1'b1; dummyPendN = 1'b0;
    end else begin
      unique case (state)
        stDev, stWaddr, stWdata: begin
          if (ev.sclRise) begin
            cmd.shiftIn = 1'b1; cntN = cnt + 4'd1;
          end else if (ev.sclFall && cnt == FULL) begin
            cntN = '0;
            if (state == stDev) begin
              dummyPendN = 1'b0;
              if (idOk) begin
                cmd.drvAck = 1'b1; selMemN = hitMem; rdModeN = rdReq;
                stateN = stDevAck;
              end else begin
                stateN = stWait;
              end
            end else if (state == stWaddr) begin
              cmd.setAddr = 1'b1; cmd.drvAck = 1'b1;
              dummyPendN = 1'b1; dummyMemN = selMem;
              stateN = stWaddrAck;
            end else begin
              cmd.drvAck = 1'b1; dummyPendN = 1'b0;
              stateN = stWdataAck;
            end
          end
        end
        stDevAck: if (ev.sclFall) begin
          if (rdMode) begin
            cmd.loadTx = 1'b1; cntN = '0; stateN = stRdata;
          end else begin
            cmd.drvRel = 1'b1; stateN = stWaddr;
          end
        end
        stWaddrAck: if (ev.sclFall) begin
          cmd.drvRel = 1'b1; stateN = stWdata;
        end
        stWdataAck: if (ev.sclFall) begin
          cmd.drvRel = 1'b1; cmd.commit = 1'b1; cmd.incAddr = 1'b1;
          stateN = stWdata;
        end
        stRdata: begin
          if (ev.sclRise) cntN = cnt + 4'd1;
          else if (ev.sclFall) begin
            if (cnt == FULL) begin
              cmd.drvRel = 1'b1; cmd.incAddr = 1'b1; cntN = '0;
              stateN = stRack;
            end else begin
              cmd.shiftOut = 1'b1;
            end
          end
        end
        stRack: begin
          if (ev.sclRise) ackSeenN = ~ev.sdaBit;
          else if (ev.sclFall) begin
            if (ackSeen) begin
              cmd.loadTx = 1'b1; cntN = '0; stateN = stRdata;
            end else begin
              stateN = stWait;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dual_id_i2c_target.sv
module dual_id_i2c_target
  import i2ct_pkg::*;
#(
  parameter int         ADDR_W = 8,
  parameter logic [6:0] CLK_ID = 7'b1101111,
  parameter logic [6:0] MEM_ID = 7'b1010111
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDrvLow,
  output logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        wrData,
  output logic              clkWe,
  output logic              memWe,
  input  logic [7:0]        clkRdData,
  input  logic [7:0]        memRdData
);
  dpCmd_t            cmd;
  busEv_t            ev;
  logic [BYTE_W-1:0] rxByte;

  i2ct_ctrl #(.CLK_ID(CLK_ID), .MEM_ID(MEM_ID)) uCtrl (
    .clk(clk), .rstN(rstN), .ev(ev), .rxByte(rxByte), .cmd(cmd)
  );

  i2ct_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .cmd(cmd),
    .ev(ev), .rxByte(rxByte), .sdaDrvLow(sdaDrvLow), .regAddr(regAddr),
    .wrData(wrData), .clkWe(clkWe), .memWe(memWe),
    .clkRdData(clkRdData), .memRdData(memRdData)
  );
endmodule

// File: rtl/i2ct_chk.sv
module i2ct_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaDrvLow,
  input logic [ADDR_W-1:0] regAddr,
  input logic [7:0]        wrData,
  input logic              clkWe,
  input logic              memWe
);
  // R6: never both banks in one cycle
  assert_we_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({clkWe, memWe}));

  // R6: commit happens only at the end of the ninth clock, with SCL low
  assert_we_scl_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clkWe || memWe) |-> !sclIn);

  // R6: write byte is held steady through its acknowledge
  assert_wrdata_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clkWe || memWe) |-> $stable(wrData));

  // R5: every commit advances the shared counter by one
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (clkWe || memWe) |=> regAddr == ADDR_W'($past(regAddr) + 1'b1));

  // R10: drive level changes only while SCL is low
  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDrvLow) |-> !sclIn);
endmodule

bind dual_id_i2c_target i2ct_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDrvLow(sdaDrvLow),
  .regAddr(regAddr), .wrData(wrData), .clkWe(clkWe), .memWe(memWe)
);

// File: tb/sim_dual_id_i2c_target.sv
`timescale 1ns/1ps
module sim_dual_id_i2c_target;
  localparam int Q = 5;
  localparam logic [6:0] CID = 7'b1101111;
  localparam logic [6:0] MID = 7'b1010111;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaDrvLow, clkWe, memWe;
  logic [7:0] regAddr, wrData, clkRdData, memRdData;
  logic sdaLine;
  logic [7:0] clkBank [256];
  logic [7:0] memBank [256];
  int total = 0, fails = 0, weCount = 0;

  always #10 clk = ~clk;
  assign sdaLine = sdaM & ~sdaDrvLow;
  assign clkRdData = clkBank[regAddr];
  assign memRdData = memBank[regAddr];

  dual_id_i2c_target u0 (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine),
    .sdaDrvLow(sdaDrvLow), .regAddr(regAddr), .wrData(wrData),
    .clkWe(clkWe), .memWe(memWe), .clkRdData(clkRdData), .memRdData(memRdData)
  );

  function automatic logic [7:0] clkInit(int a); return 8'(a * 3 + 1); endfunction
  function automatic logic [7:0] memInit(int a); return 8'(a) ^ 8'h5A; endfunction
  function automatic logic [7:0] sweepVal(int a); return 8'(a * 5 + 7); endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) begin
        clkBank[i] <= clkInit(i);
        memBank[i] <= memInit(i);
      end
    end else begin
      if (clkWe) clkBank[regAddr] <= wrData;
      if (memWe) memBank[regAddr] <= wrData;
      if (clkWe || memWe) weCount <= weCount + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic busStart;
    sdaM = 1'b1; wt(Q); sclM = 1'b1; wt(2*Q);
    sdaM = 1'b0; wt(2*Q); sclM = 1'b0; wt(Q);
  endtask

  task automatic busStop;
    sdaM = 1'b0; wt(Q); sclM = 1'b1; wt(2*Q); sdaM = 1'b1; wt(2*Q);
  endtask

  task automatic sendBit(input logic b);
    sdaM = b; wt(Q); sclM = 1'b1; wt(2*Q); sclM = 1'b0; wt(Q);
  endtask

  // samples twice in the high phase; R10 stability
  task automatic recvBit(output logic b);
    logic b2;
    sdaM = 1'b1; wt(Q); sclM = 1'b1; wt(Q);
    b = sdaLine; wt(Q - 1); b2 = sdaLine;
    check(b == b2, "R10 level stable while SCL high", int'(b2), int'(b));
    wt(1); sclM = 1'b0; wt(Q);
  endtask

  task automatic sendByte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    recvBit(a);
    ack = ~a;
  endtask

  task automatic recvByte(input bit ackIt, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recvBit(b);
      d[i] = b;
    end
    sendBit(~ackIt);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] d;
    int wc;
    wt(5);
    check(sdaDrvLow == 1'b0, "R4 reset drive", sdaDrvLow, 0);
    check(regAddr == 8'h00, "R4 reset counter", regAddr, 0);
    check(!clkWe && !memWe, "R4 reset strobes", {clkWe, memWe}, 0);
    rstN = 1'b1;
    wt(5);

    // current-address read right after reset
    busStart; sendByte({CID, 1'b1}, ack);
    check(ack, "R2 read slave byte ack", ack, 1);
    recvByte(1'b0, d);
    check(d == clkInit(0), "R4 first read at 00h", d, clkInit(0));
    wt(Q);
    check(sdaDrvLow == 1'b0, "R8 release after nack", sdaDrvLow, 0);
    busStop;

    // identifier sweep, write direction
    for (int id = 0; id < 128; id++) begin
      logic exp;
      exp = (7'(id) == CID) || (7'(id) == MID);
      busStart; sendByte({7'(id), 1'b0}, ack);
      check(ack == exp, "R1 identifier decode", ack, exp);
      busStop;
    end
    busStart; sendByte({7'b1101110, 1'b1}, ack);
    check(!ack, "R1 foreign id read", ack, 0);
    check(sdaDrvLow == 1'b0, "R1 silent after foreign id", sdaDrvLow, 0);
    busStop;

    // memory-bank write crossing FFh
    wc = weCount;
    busStart; sendByte({MID, 1'b0}, ack);
    check(ack, "R3 slave ack", ack, 1);
    sendByte(8'hFE, ack);
    check(ack, "R3 word address ack", ack, 1);
    sendByte(8'h11, ack); check(ack, "R3 data ack", ack, 1);
    sendByte(8'h22, ack); check(ack, "R3 data ack", ack, 1);
    sendByte(8'h33, ack); check(ack, "R3 data ack", ack, 1);
    check(sdaDrvLow == 1'b0, "R3 release after ack", sdaDrvLow, 0);
    busStop; wt(2);
    check(memBank[8'hFE] == 8'h11, "R6 write FE", memBank[8'hFE], 8'h11);
    check(memBank[8'hFF] == 8'h22, "R6 write FF", memBank[8'hFF], 8'h22);
    check(memBank[8'h00] == 8'h33, "R5 wrap to 00", memBank[8'h00], 8'h33);
    check(clkBank[8'hFE] == clkInit(8'hFE), "R6 other bank untouched", clkBank[8'hFE], clkInit(8'hFE));
    check(weCount == wc + 3, "R6 strobe count", weCount - wc, 3);

    // random read in the clock bank
    busStart; sendByte({CID, 1'b0}, ack); sendByte(8'h40, ack);
    busStart; sendByte({CID, 1'b1}, ack);
    check(ack, "R7 matching id read", ack, 1);
    for (int k = 0; k < 3; k++) begin
      recvByte(k != 2, d);
      check(d == clkInit(8'h40 + k), "R8 sequential read", d, clkInit(8'h40 + k));
    end
    busStop;

    // counter shared across banks
    busStart; sendByte({MID, 1'b1}, ack);
    recvByte(1'b0, d);
    check(d == memInit(8'h43), "R5 counter carried across banks", d, memInit(8'h43));
    busStop;

    // mismatched identifier in random read
    busStart; sendByte({CID, 1'b0}, ack); sendByte(8'h20, ack);
    busStart; sendByte({MID, 1'b1}, ack);
    check(!ack, "R7 mismatched id not acked", ack, 0);
    busStop;
    busStart; sendByte({CID, 1'b1}, ack); recvByte(1'b0, d);
    check(d == clkInit(8'h20), "R4 word address loaded", d, clkInit(8'h20));
    busStop;

    // STOP in mid-byte
    wc = weCount;
    busStart; sendByte({MID, 1'b0}, ack); sendByte(8'h80, ack);
    for (int i = 0; i < 4; i++) sendBit(1'b0);
    busStop; wt(2);
    check(weCount == wc, "R9 aborted byte not written", weCount - wc, 0);
    check(memBank[8'h80] == memInit(8'h80), "R9 location kept", memBank[8'h80], memInit(8'h80));
    busStart; sendByte({MID, 1'b1}, ack); recvByte(1'b0, d);
    check(d == memInit(8'h80), "R9 counter kept", d, memInit(8'h80));
    busStop;

    // full sweep of the clock bank, write then read with wrap
    busStart; sendByte({CID, 1'b0}, ack); sendByte(8'h00, ack);
    for (int a = 0; a < 256; a++) begin
      sendByte(sweepVal(a), ack);
      check(ack, "R3 sweep data ack", ack, 1);
    end
    busStop;
    busStart; sendByte({CID, 1'b1}, ack);
    for (int a = 0; a < 256; a++) begin
      recvByte(a != 255, d);
      check(d == sweepVal(a), "R5 sweep readback", d, sweepVal(a));
    end
    busStop;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule